// File: doc/BRIEF.md
# Pin Boundary Scan Register Chain

This block is the I/O data register of a boundary scan path for a small programmable device. Each pad gets one or more scan cells. A cell can sample a parallel value, pass bits serially from the test data input toward the test data output, and hold a separately updated copy. Bidirectional pads take three cells: input sample, output value and drive enable. Input-only pads take one cell. Output-only pads still take all three. Two probe cells sit at the head of the chain and sample an internal value and its enable. One trailing cell drives an internal net from its updated copy.

The strobes come from an external test access port controller. These are a shift/capture select, a data-register clock enable, an update enable and the external-test selection, all synchronous to `clk`. When external test is selected, the updated copies drive the pads in place of the core logic. Otherwise the core signals pass straight to the pads.

Top module: `pinScanChain`

## Requirements
- R1: The chain length is L = 3*NUM_BIDIR + NUM_IN + 3*NUM_OUT + 3. Position 0 feeds `tdo` and position L-1 receives `tdi`. Position 0 is the probe-enable cell and position 1 is the probe-value cell. Bidirectional pad k occupies positions 2+3k (input), 3+3k (output) and 4+3k (enable). Input-only pads follow with one position each. Output-only pads come next with three positions each (input, output, enable). Position L-1 is the internal-net cell.
- R2: A cycle with `clockDr`=1 and `shiftSel`=1 moves every bit one position toward `tdo` and loads `tdi` into position L-1. A pattern shifted in therefore appears at `tdo` after exactly L shift cycles, first bit first.
- R3: A cycle with `clockDr`=1 and `shiftSel`=0 loads every position in parallel. Input cells take `padIn`, output cells take `coreOut`, enable cells take `coreOe`, position 0 takes `probeEn`, position 1 takes `probeVal`, and position L-1 takes the current `userNet`.
- R4: With `clockDr`=0 the chain contents do not change.
- R5: A cycle with `updateDr`=1 copies the output, enable and internal-net positions of the chain into their update latches. The latches hold their value until the next such cycle.
- R6: With `extestEn`=1, `padOut` and `padOe` equal the updated output and enable latches of each driving pad (1 = drive).
- R7: With `extestEn`=0, `padOut` equals `coreOut` and `padOe` equals `coreOe`, whatever the latches contain.
- R8: Reset (active-low `rst_n`) clears the chain and all update latches to 0. While reset is held, external test is forced off.
- R9: When `clockDr` and `updateDr` are both 1 in one cycle, the latches take the chain contents from before that edge's shift.
- R10: `userNet` always shows the internal-net latch, independent of `extestEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shiftSel | input | 1 | 1 = shift, 0 = capture |
| clockDr | input | 1 | Data-register clock enable |
| updateDr | input | 1 | Update latch enable |
| extestEn | input | 1 | External test selected |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (position 0) |
| probeVal | input | 1 | Internal value captured at position 1 |
| probeEn | input | 1 | Internal enable captured at position 0 |
| padIn | input | NUM_BIDIR+NUM_IN+NUM_OUT | Pad-side input values |
| coreOut | input | NUM_BIDIR+NUM_OUT | Core output values for driving pads |
| coreOe | input | NUM_BIDIR+NUM_OUT | Core drive enables (1 = drive) |
| padOut | output | NUM_BIDIR+NUM_OUT | Pad output value |
| padOe | output | NUM_BIDIR+NUM_OUT | Pad drive enable (1 = drive) |
| userNet | output | 1 | Internal net from the trailing cell |

## Verification
Shifting and updating can fall on the same edge. The bench loads a known pattern and then issues one cycle with both `clockDr` and `updateDr` raised. Under external test it checks that the pads show the pattern as it stood before that shift. It also unloads the chain and checks that it holds the once-shifted pattern with the new `tdi` bit at the far end.

// File: rtl/scanPkg.sv
package scanPkg;

  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
    logic extest;
  } scanStrobes_t;

  // Chain position of the input cell for receive index r
  function automatic int posIn(input int r, input int nBi, input int nIn);
    if (r < nBi) return 2 + 3 * r;
    else if (r < nBi + nIn) return 2 + 3 * nBi + (r - nBi);
    else return 2 + 3 * nBi + nIn + 3 * (r - nBi - nIn);
  endfunction

  // Chain position of the output cell for driver index d
  function automatic int posOut(input int d, input int nBi, input int nIn);
    if (d < nBi) return 3 + 3 * d;
    else return 3 + 3 * nBi + nIn + 3 * (d - nBi);
  endfunction

endpackage

// File: rtl/scanCtrl.sv
module scanCtrl
  import scanPkg::*;
(
  input  logic         rst_n,
  input  logic         shiftSel,
  input  logic         clockDr,
  input  logic         updateDr,
  input  logic         extestEn,
  output scanStrobes_t strobes
);
  always_comb begin
    strobes.capture = rst_n & clockDr & ~shiftSel;
    strobes.shift   = rst_n & clockDr & shiftSel;
    strobes.update  = rst_n & updateDr;
    strobes.extest  = rst_n & extestEn;
  end
endmodule

// File: rtl/scanPath.sv
module scanPath
  import scanPkg::*;
#(
  parameter int NUM_BIDIR = 3,
  parameter int NUM_IN    = 2,
  parameter int NUM_OUT   = 1,
  localparam int NUM_DRV  = NUM_BIDIR + NUM_OUT,
  localparam int NUM_RX   = NUM_BIDIR + NUM_IN + NUM_OUT,
  localparam int CHAIN_LEN = 3 * NUM_BIDIR + NUM_IN + 3 * NUM_OUT + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  scanStrobes_t         strobes,
  input  logic                 tdi,
  input  logic                 probeVal,
  input  logic                 probeEn,
  input  logic [NUM_RX-1:0]    padIn,
  input  logic [NUM_DRV-1:0]   coreOut,
  input  logic [NUM_DRV-1:0]   coreOe,
  output logic [NUM_DRV-1:0]   padOut,
  output logic [NUM_DRV-1:0]   padOe,
  output logic                 userNet,
  output logic                 tdo,
  output logic [CHAIN_LEN-1:0] shiftReg
);
  logic [CHAIN_LEN-1:0] capVec;
  logic [NUM_DRV-1:0]   updOut, updOe;
  logic                 updUser;

  assign capVec[0]           = probeEn;
  assign capVec[1]           = probeVal;
  assign capVec[CHAIN_LEN-1] = updUser;

  for (genvar r = 0; r < NUM_RX; r++) begin : g_rx
    localparam int P = posIn(r, NUM_BIDIR, NUM_IN);
    assign capVec[P] = padIn[r];
  end

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
    localparam int P = posOut(d, NUM_BIDIR, NUM_IN);
    assign capVec[P]   = coreOut[d];
    assign capVec[P+1] = coreOe[d];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        updOut[d] <= 1'b0;
        updOe[d]  <= 1'b0;
      end else if (strobes.update) begin
        updOut[d] <= shiftReg[P];
        updOe[d]  <= shiftReg[P+1];
      end
    end

    assign padOut[d] = strobes.extest ? updOut[d] : coreOut[d];
    assign padOe[d]  = strobes.extest ? updOe[d]  : coreOe[d];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               shiftReg <= '0;
    else if (strobes.shift)   shiftReg <= {tdi, shiftReg[CHAIN_LEN-1:1]};
    else if (strobes.capture) shiftReg <= capVec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              updUser <= 1'b0;
    else if (strobes.update) updUser <= shiftReg[CHAIN_LEN-1];
  end

  assign userNet = updUser;
  assign tdo     = shiftReg[0];
endmodule

// File: rtl/pinScanChain.sv
module pinScanChain
  import scanPkg::*;
#(
  parameter int NUM_BIDIR = 3,
  parameter int NUM_IN    = 2,
  parameter int NUM_OUT   = 1,
  localparam int NUM_DRV  = NUM_BIDIR + NUM_OUT,
  localparam int NUM_RX   = NUM_BIDIR + NUM_IN + NUM_OUT,
  localparam int CHAIN_LEN = 3 * NUM_BIDIR + NUM_IN + 3 * NUM_OUT + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shiftSel,
  input  logic               clockDr,
  input  logic               updateDr,
  input  logic               extestEn,
  input  logic               tdi,
  output logic               tdo,
  input  logic               probeVal,
  input  logic               probeEn,
  input  logic [NUM_RX-1:0]  padIn,
  input  logic [NUM_DRV-1:0] coreOut,
  input  logic [NUM_DRV-1:0] coreOe,
  output logic [NUM_DRV-1:0] padOut,
  output logic [NUM_DRV-1:0] padOe,
  output logic               userNet
);
  scanStrobes_t         strobes;
  logic [CHAIN_LEN-1:0] shiftReg;

  scanCtrl ctrl_i (
    .rst_n(rst_n), .shiftSel(shiftSel), .clockDr(clockDr),
    .updateDr(updateDr), .extestEn(extestEn), .strobes(strobes)
  );

  scanPath #(.NUM_BIDIR(NUM_BIDIR), .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) path_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .tdi(tdi),
    .probeVal(probeVal), .probeEn(probeEn), .padIn(padIn),
    .coreOut(coreOut), .coreOe(coreOe), .padOut(padOut), .padOe(padOe),
    .userNet(userNet), .tdo(tdo), .shiftReg(shiftReg)
  );
endmodule

// File: rtl/scanChainChk.sv
module scanChainChk #(
  parameter int NUM_BIDIR = 3,
  parameter int NUM_IN    = 2,
  parameter int NUM_OUT   = 1,
  localparam int NUM_DRV  = NUM_BIDIR + NUM_OUT,
  localparam int CHAIN_LEN = 3 * NUM_BIDIR + NUM_IN + 3 * NUM_OUT + 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 shiftSel,
  input logic                 clockDr,
  input logic                 updateDr,
  input logic                 extestEn,
  input logic                 tdi,
  input logic [NUM_DRV-1:0]   coreOut,
  input logic [NUM_DRV-1:0]   coreOe,
  input logic [NUM_DRV-1:0]   padOut,
  input logic [NUM_DRV-1:0]   padOe,
  input logic                 userNet,
  input logic [CHAIN_LEN-1:0] shiftReg
);
  p_shift_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clockDr && shiftSel) |=>
      (shiftReg == {$past(tdi), $past(shiftReg[CHAIN_LEN-1:1])}));

  p_chain_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clockDr |=> $stable(shiftReg));

  p_latch_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !updateDr |=> $stable(userNet));

  p_core_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !extestEn |-> (padOut == coreOut && padOe == coreOe));

  p_extest_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (extestEn && !updateDr) |=> (extestEn -> $stable(padOut)));
endmodule

bind pinScanChain scanChainChk #(
  .NUM_BIDIR(NUM_BIDIR), .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)
) chk_i (.*);

// File: tb/pinScanChain_tb_top.sv
module pinScanChain_tb_top;
  localparam int B = 3, I = 2, O = 1;
  localparam int D = B + O, RX = B + I + O;
  localparam int L = 3 * B + I + 3 * O + 3;

  logic clk = 0, rst_n = 0;
  logic shiftSel = 0, clockDr = 0, updateDr = 0, extestEn = 0, tdi = 0;
  logic probeVal = 0, probeEn = 0;
  logic [RX-1:0] padIn = '0;
  logic [D-1:0]  coreOut = '0, coreOe = '0;
  logic tdo, userNet;
  logic [D-1:0] padOut, padOe;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pinScanChain #(.NUM_BIDIR(B), .NUM_IN(I), .NUM_OUT(O)) dut_i (.*);

  // bench-side position model (R1)
  function automatic int inPos(int r);
    if (r < B) return 2 + 3 * r;
    if (r < B + I) return 2 + 3 * B + r - B;
    return 2 + 3 * B + I + 3 * (r - B - I);
  endfunction
  function automatic int outPos(int d);
    if (d < B) return 3 + 3 * d;
    return 2 + 3 * B + I + 3 * (d - B) + 1;
  endfunction
  function automatic logic [D-1:0] expDrv(logic [L-1:0] v, bit oe);
    logic [D-1:0] e;
    for (int d = 0; d < D; d++) e[d] = v[outPos(d) + (oe ? 1 : 0)];
    return e;
  endfunction
  function automatic logic [L-1:0] expCap(logic un);
    logic [L-1:0] e;
    e[0] = probeEn; e[1] = probeVal; e[L-1] = un;
    for (int r = 0; r < RX; r++) e[inPos(r)] = padIn[r];
    for (int d = 0; d < D; d++) begin
      e[outPos(d)] = coreOut[d]; e[outPos(d)+1] = coreOe[d];
    end
    return e;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(logic sh, logic cd, logic up, logic t);
    @(negedge clk);
    shiftSel = sh; clockDr = cd; updateDr = up; tdi = t;
    @(negedge clk);
    clockDr = 0; updateDr = 0;
  endtask

  task automatic loadPat(logic [L-1:0] p);
    for (int j = 0; j < L; j++) tick(1, 1, 0, p[j]);
  endtask

  task automatic unload(output logic [L-1:0] got);
    for (int j = 0; j < L; j++) begin
      got[j] = tdo;
      tick(1, 1, 0, 1'b0);
    end
  endtask

  task automatic checkLatched(string req, logic [L-1:0] lat);
    extestEn = 1;
    @(negedge clk);
    check({req, " padOut"}, 64'(padOut), 64'(expDrv(lat, 0)));
    check({req, " padOe"}, 64'(padOe), 64'(expDrv(lat, 1)));
    check({req, " userNet"}, 64'(userNet), 64'(lat[L-1]));
  endtask

  initial begin
    logic [L-1:0] p1, p2, got, lat;
    void'($urandom(32'h5EED));
    coreOut = 4'b1010; coreOe = 4'b0110;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 / R7: reset state, pads follow core
    check("R8 userNet", 64'(userNet), 64'(0));
    check("R7 padOut", 64'(padOut), 64'(coreOut));
    check("R7 padOe", 64'(padOe), 64'(coreOe));
    checkLatched("R8 cleared latches", '0);
    extestEn = 0;
    unload(got);
    check("R8 chain clear", 64'(got), 64'(0));

    // R2: pattern emerges after exactly L shifts
    p1 = L'(64'h1_A5C3);
    loadPat(p1);
    check("R2 first bit after L shifts", 64'(tdo), 64'(p1[0]));
    repeat (4) @(negedge clk);  // R4: idle cycles
    unload(got);
    check("R2/R4 shifted stream", 64'(got), 64'(p1));

    // R5/R6/R10: update then external test
    loadPat(p1);
    tick(0, 0, 1, 0);
    checkLatched("R6 R10 extest", p1);
    // R5: new pattern without update leaves pads unchanged
    p2 = ~p1;
    loadPat(p2);
    checkLatched("R5 hold", p1);
    // R7: core passthrough with latches loaded
    extestEn = 0;
    @(negedge clk);
    check("R7 pass padOut", 64'(padOut), 64'(coreOut));
    check("R7 pass padOe", 64'(padOe), 64'(coreOe));

    // R9: shift and update on one edge
    tick(1, 1, 1, 1'b1);
    checkLatched("R9 pre-shift latch", p2);
    extestEn = 0;
    unload(got);
    check("R9 chain after shift", 64'(got), 64'({1'b1, p2[L-1:1]}));

    // R3: capture, random inputs
    for (int k = 0; k < 20; k++) begin
      padIn = RX'($urandom); coreOut = D'($urandom); coreOe = D'($urandom);
      probeVal = 1'($urandom); probeEn = 1'($urandom);
      lat = expCap(userNet);
      tick(0, 1, 0, 0);
      unload(got);
      check("R3 R1 capture", 64'(got), 64'(lat));
      // random load/update/extest round (R2 R5 R6 R10)
      p1 = L'({$urandom, $urandom});
      loadPat(p1);
      tick(0, 0, 1, 0);
      checkLatched("R6 R10 random", p1);
      extestEn = 0;
      @(negedge clk);
      check("R7 random pass", 64'({padOe, padOut}), 64'({coreOe, coreOut}));
    end

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule